// File: doc/BRIEF.md
# Serial Clock Generator with Separate High and Low Phases

This block makes the serial clock for a flash serial-interface controller. It divides the system clock by a programmable amount and gives the transfer engine two single-cycle strobes: one on each rising serial-clock edge, for sampling input data, and one on each falling edge, for shifting out the next bit. The only clock mode is mode 0. The clock idles low, and the first edge of a burst is a rising edge.

A 32-bit configuration word sets the output clock.
- The period field sets the period. The clock repeats every `div + 1` system cycles.
- The high-phase field sets how long the clock stays high at the start of each period.
- The low-phase field is never read. The low phase simply fills the rest of the period.

The configuration word is captured only while the generator is idle. Software can therefore rewrite it during a burst without disturbing the clock already running. The source-select bit is captured with the same rule and presented on a port.

Top module: `sclk_phase_gen`

## Requirements
- R1: The configuration word is decoded as follows. The period value `div` is in bits 17:12. The high-phase value `hi` is in bits 11:6. The source-select flag is in bit 31. Bits 5:0 (the low-phase count) and bits 30:18 have no effect on any output.
- R2: While running, `sck` repeats with a period of `div + 1` system cycles. A `div` of 0 behaves as 1, so the fastest clock is the system clock divided by 2 and the slowest is divided by 64.
- R3: In each period, `sck` is high for the first `hi + 1` cycles and low for the rest. A `hi` that is not below `div` (after the R2 adjustment) is treated as `div - 1`.
- R4: In the first cycle after `run_en` rises, `sck` is high and `sample_stb` is asserted.
- R5: In the first cycle after `run_en` falls, the outputs are: `sck` low, `idle` high, and neither strobe asserted. While idle, `sck` stays low.
- R6: `sample_stb` is high for exactly the first cycle of each high phase. `shift_stb` is high for exactly the first cycle of each low phase. The two strobes are never high together.
- R7: Changes to `clk_cfg` while running have no effect on the outputs. The value present in the cycle `run_en` is first sampled high sets the next burst.
- R8: `src_sel` shows the captured bit 31. It holds its value while running.
- R9: After reset, `idle` is 1 and `sck`, `sample_stb`, `shift_stb` and `src_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run request from the transfer engine |
| clk_cfg | input | 32 | Configuration word (period, high phase, source select) |
| sck | output | 1 | Serial clock, mode 0 |
| sample_stb | output | 1 | One-cycle pulse on each rising `sck` edge |
| shift_stb | output | 1 | One-cycle pulse on each falling `sck` edge |
| idle | output | 1 | High while the generator is stopped |
| src_sel | output | 1 | Captured clock-source select flag |

## Verification
A wrong phase count or wrap value shows up at `sck` within one period. That is at most 64 cycles after the first rising edge, as a pulse that is too long, too short, or misplaced. The strobes then land in the wrong cycles. A capture window that stays open while running shows up in the first cycle after `clk_cfg` is disturbed, as a changed phase or a changed `src_sel`. A counter that is not cleared at stop shows up at the first cycle of the next burst, as a missing `sample_stb`. The bench checks every cycle of two full periods for all 64 period values, with several high-phase settings each.

// File: rtl/sclk_pkg.sv
// Shared constants for the serial clock generator: configuration word layout.
package sclk_pkg;
    localparam int CFG_W   = 32;  // configuration word width
    localparam int FLD_W   = 6;   // width of the period and high-phase fields
    localparam int HI_LSB  = 6;   // high-phase field position
    localparam int DIV_LSB = 12;  // period field position
    localparam int SRC_BIT = 31;  // source-select flag position

    // Decoded and adjusted settings that the generator runs from.
    typedef struct packed {
        logic             src;
        logic [FLD_W-1:0] div;
        logic [FLD_W-1:0] hi;
    } sclk_cfg_t;
endpackage

// File: rtl/sclk_cfg_latch.sv
// Configuration capture.
// Decodes the configuration word and adjusts its fields: a period of 0 becomes 1,
// and the high phase is limited to period-1. It captures the result every cycle
// while idle and holds it while running.
// Assumes `running` is the registered run state of the top module.
module sclk_cfg_latch
    import sclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [CFG_W-1:0] cfg_word,
    output sclk_cfg_t        cfg_q
);
    localparam int GAP_LSB = DIV_LSB + FLD_W;

    logic [FLD_W-1:0] raw_div;
    logic [FLD_W-1:0] raw_hi;
    sclk_cfg_t        cfg_d;
    logic             cfg_unused;

    assign raw_div    = cfg_word[DIV_LSB +: FLD_W];
    assign raw_hi     = cfg_word[HI_LSB +: FLD_W];
    assign cfg_unused = ^{cfg_word[SRC_BIT-1:GAP_LSB], cfg_word[HI_LSB-1:0]};

    // Adjust the raw fields into legal running values.
    always_comb begin
        cfg_d.src = cfg_word[SRC_BIT];
        cfg_d.div = (raw_div == '0) ? FLD_W'(1) : raw_div;
        cfg_d.hi  = (raw_hi >= cfg_d.div) ? cfg_d.div - FLD_W'(1) : raw_hi;
    end

    // Capture while idle, hold while running.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= '{src: 1'b0, div: FLD_W'(1), hi: '0};
        else if (!running) cfg_q <= cfg_d;
    end

    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> $stable(cfg_q));
    p_hi_below_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.hi < cfg_q.div);
endmodule

// File: rtl/sclk_phase_cnt.sv
// Phase counter.
// Counts 0..div and wraps; the clock is high while the count is at or below hi.
// Assumes hi < div and div >= 1, both held stable while running.
module sclk_phase_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         running,
    input  logic [W-1:0] div,
    input  logic [W-1:0] hi,
    output logic         sck
);
    logic [W-1:0] cnt;

    // Advance the count through one period; clear it when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) cnt <= '0;
        else if (cnt == div)    cnt <= '0;
        else                    cnt <= cnt + W'(1);
    end

    assign sck = running && (cnt <= hi);

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= div));
    p_cnt_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (cnt == '0));
endmodule

// File: rtl/sclk_edge_strobe.sv
// Edge strobes.
// Compares the clock with its value one cycle earlier and pulses on rising
// (sample) and falling (shift) edges. No strobe fires when the clock stops.
module sclk_edge_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic sck,
    output logic rise_stb,
    output logic fall_stb
);
    logic sck_prev;

    // Remember the previous clock level; forced low while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) sck_prev <= 1'b0;
        else                    sck_prev <= sck;
    end

    assign rise_stb = running &&  sck && !sck_prev;
    assign fall_stb = running && !sck &&  sck_prev;

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));
    p_rise_follows_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb);
endmodule

// File: rtl/sclk_phase_gen.sv
// Serial clock generator, mode 0.
// Registers the run request, captures the configuration while idle, and
// produces the serial clock, the sample and shift strobes, and the idle flag.
// Assumes run_en is synchronous to clk.
module sclk_phase_gen
    import sclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CFG_W-1:0] clk_cfg,
    output logic             sck,
    output logic             sample_stb,
    output logic             shift_stb,
    output logic             idle,
    output logic             src_sel
);
    logic      running;
    sclk_cfg_t cfg_q;

    // Register the run request.
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= run_en;
    end

    sclk_cfg_latch u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .cfg_word (clk_cfg),
        .cfg_q    (cfg_q)
    );

    sclk_phase_cnt #(.W(FLD_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .div     (cfg_q.div),
        .hi      (cfg_q.hi),
        .sck     (sck)
    );

    sclk_edge_strobe u_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .sck      (sck),
        .rise_stb (sample_stb),
        .fall_stb (shift_stb)
    );

    assign idle    = !running;
    assign src_sel = cfg_q.src;

    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!sck && !sample_stb && !shift_stb));
    p_first_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (sck && sample_stb));
    p_src_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> $stable(src_sel));
endmodule

// File: tb/sclk_phase_gen_tb.sv
// Bench: sweeps every period value with several high-phase settings and checks
// every output in every cycle against an arithmetic model.
module sclk_phase_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [31:0] clk_cfg = '0;
    logic        sck, sample_stb, shift_stb, idle, src_sel;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    sclk_phase_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .clk_cfg    (clk_cfg),
        .sck        (sck),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb),
        .idle       (idle),
        .src_sel    (src_sel)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input int src, input int n, input int h, input int lo, input int gap);
        return {src[0], gap[12:0], n[5:0], h[5:0], lo[5:0]};
    endfunction

    // One burst: program at idle, start, check 2 periods plus one cycle, stop.
    // With disturb set, clk_cfg is scrambled every running cycle.
    task automatic burst(input int src, input int n, input int h, input int lo, input bit disturb);
        int ne, he, cycles;
        ne = (n == 0) ? 1 : n;
        he = (h >= ne) ? ne - 1 : h;
        cycles = 2 * (ne + 1) + 1;
        clk_cfg = mk_cfg(src, n, h, lo, 13'h1A5A);  // R1: bits 30:18 set, ignored
        run_en  = 1'b1;
        for (int k = 0; k < cycles; k++) begin
            int c;
            @(negedge clk);
            c = k % (ne + 1);
            if (k == 0) begin
                chk("R4", "first sck", sck, 1);
                chk("R4", "first sample_stb", sample_stb, 1);
            end
            chk("R3", "sck level", sck, (c <= he) ? 1 : 0);
            chk("R2", "idle while running", idle, 0);
            chk("R6", "sample_stb", sample_stb, (c == 0) ? 1 : 0);
            chk("R6", "shift_stb", shift_stb, (c == he + 1) ? 1 : 0);
            chk(disturb ? "R7" : "R8", "src_sel", src_sel, src);
            if (disturb) clk_cfg = ~mk_cfg(src, n, h, lo, 0) ^ 32'(k);
        end
        run_en = 1'b0;
        @(negedge clk);
        chk("R5", "sck after stop", sck, 0);
        chk("R5", "idle after stop", idle, 1);
        chk("R5", "shift_stb after stop", shift_stb, 0);
        chk("R5", "sample_stb after stop", sample_stb, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "idle in reset", idle, 1);
        chk("R9", "sck in reset", sck, 0);
        chk("R9", "sample_stb in reset", sample_stb, 0);
        chk("R9", "shift_stb in reset", shift_stb, 0);
        chk("R9", "src_sel in reset", src_sel, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "idle after reset", idle, 1);
        chk("R5", "sck while idle", sck, 0);

        // R2/R3: sweep every period with the minimum, nominal and over-range high phase
        for (int n = 0; n < 64; n++) begin
            int nom;
            nom = (n + 1) / 2 - 1;
            if (nom < 0) nom = 0;
            burst(n % 2, n, 0, n, 1'b0);
            burst(0, n, nom, 63 - n, 1'b0);
            burst(1, n, 63, 0, 1'b0);
        end

        // R1: the low-phase field alone must not change the waveform
        for (int lo = 0; lo < 64; lo += 9) burst(0, 5, 2, lo, 1'b0);

        // R7: rewrite during a burst is ignored; the next burst takes the new value
        burst(1, 9, 3, 0, 1'b1);
        burst(0, 2, 0, 0, 1'b1);
        burst(1, 17, 11, 4, 1'b0);

        // R5: long idle stays low
        repeat (10) begin
            @(negedge clk);
            chk("R5", "sck held idle", sck, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule